// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a small, fully associative translation buffer that software fills one slot at a time. Each slot describes a pair of adjacent virtual pages. The slot holds a tag, an address-space identifier, a global flag, a variable page-size mask and two physical halves. Each half is an even or odd page with its own frame number, cache attribute, dirty flag and valid flag. A slot matches on the tag bits that its mask does not cover. The identifier must also match, unless the slot is global.

The lookup port takes a virtual address, an address-space identifier and two qualifiers: instruction fetch or data access, and read or write. One cycle later it returns either a physical address or a fault code. A fault code comes with the values a fault handler needs. A separate probe port reports which slot matches a given address and identifier. An indexed write port fills a slot, a readback port returns a slot in packed form, and a flush input empties the whole table. A mode input selects small (1 KB) pages.

Top module: `ptlb_top`

## Requirements
- R1: A slot matches when at least one of its halves is valid, the global flag is set or the lookup identifier equals the slot's identifier, and the lookup page number equals the slot's page number in every bit that the slot's ignore set leaves uncovered. The ignore set is as follows. With `small_pg`=0 it is page-number bits [1:0] together with the mask placed at page-number bits [MASK_W+1:2]. With `small_pg`=1 it is the mask placed at page-number bits [MASK_W-1:0].
- R2: The lookup page number is the virtual address from bit 11 upward. When `small_pg`=0, its bits [1:0] are forced to zero.
- R3: Each slot stores a page shift when it is written. The shift is 12, or 10 when `small_pg`=1, plus the number of set mask bits. The virtual address bit at that shift selects the half: 0 selects the even half and 1 selects the odd half.
- R4: When no slot matches, `lk_fault` is 1 (refill, instruction fetch) or 2 (refill, data access).
- R5: When a slot matches but the selected half is not valid, `lk_fault` is 3 (invalid, instruction fetch) or 4 (invalid, data access). This takes precedence over R6.
- R6: A data write to a valid half whose dirty flag is clear gives `lk_fault`=5 (modified). A read, or any instruction fetch, to the same half gives no fault.
- R7: On a fault, the block outputs the following: the virtual address in `lk_badva`, the identifier in `lk_f_asid`, page number >> 2 in both `lk_vpn2` and `lk_ctx_vpn2`, and page number bits [1:0] in `lk_vpn2x`. Without a fault, all five are zero.
- R8: When there is no fault, `lk_fault`=0. `lk_pa` is formed in two steps. First, the frame number shifted left by 12 has every bit below the page shift cleared. Second, the virtual address bits below the page shift are ORed in. On a fault, `lk_pa` is zero.
- R9: A write with `wr_idx` >= ENTRIES leaves the table unchanged. `flush` clears every field of every slot.
- R10: One cycle after `rd_idx` is applied, the readback port shows the slot in packed form. `rd_tag` is page number << 11 | identifier. Each half is frame << 6 | attribute << 3 | dirty << 2 | valid << 1 | global.
- R11: When several slots match, the lowest index wins. The probe port reports `pr_found`=1 with that index, or `pr_found`=0 with index 0.
- R12: Results come one cycle after the request. `lk_vld` and `pr_vld` pulse for exactly one cycle per request. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| small_pg | input | 1 | Small-page mode |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_write | input | 1 | Data write qualifier |
| lk_vld | output | 1 | Lookup result strobe |
| lk_fault | output | 3 | Fault code (0 none) |
| lk_pa | output | PA_W | Physical address |
| lk_badva | output | VA_W | Faulting virtual address |
| lk_f_asid | output | ASID_W | Faulting identifier |
| lk_vpn2 | output | VPN_W-2 | Page number >> 2 |
| lk_vpn2x | output | 2 | Page number bits [1:0] |
| lk_ctx_vpn2 | output | VPN_W-2 | Context bad page pair |
| pr_req | input | 1 | Probe request |
| pr_va | input | VA_W | Probe virtual address |
| pr_asid | input | ASID_W | Probe identifier |
| pr_vld | output | 1 | Probe result strobe |
| pr_found | output | 1 | Probe hit |
| pr_idx | output | IDX_W | Matching slot index |
| wr_en | input | 1 | Slot write enable |
| wr_idx | input | IDX_W+1 | Slot write index |
| wr_vpn | input | VPN_W | Tag page number |
| wr_asid | input | ASID_W | Slot identifier |
| wr_mask | input | MASK_W | Page-size mask |
| wr_glob | input | 1 | Global flag |
| wr_pfn_e | input | PFN_W | Even frame number |
| wr_ca_e | input | CA_W | Even cache attribute |
| wr_dirty_e | input | 1 | Even dirty flag |
| wr_valid_e | input | 1 | Even valid flag |
| wr_pfn_o | input | PFN_W | Odd frame number |
| wr_ca_o | input | CA_W | Odd cache attribute |
| wr_dirty_o | input | 1 | Odd dirty flag |
| wr_valid_o | input | 1 | Odd valid flag |
| flush | input | 1 | Clear all slots |
| rd_idx | input | IDX_W+1 | Readback index |
| rd_tag | output | VA_W | Packed tag word |
| rd_even | output | PFN_W+CA_W+3 | Packed even half |
| rd_odd | output | PFN_W+CA_W+3 | Packed odd half |
| rd_mask | output | MASK_W | Slot mask |

## Verification
Lookup, probe and readback results are each due one clock edge after their request. The bench applies each request just after a falling edge and reads the result at the next falling edge, after exactly one rising edge. A slot write or flush takes effect at the rising edge that samples it, so it governs a lookup issued in the following cycle. The bench therefore finishes every write before it issues the request that depends on it. Strobe width is checked by sampling one further falling edge and expecting `lk_vld` to be low.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_REFILL_I = 3'd1,
    FLT_REFILL_D = 3'd2,
    FLT_INVAL_I  = 3'd3,
    FLT_INVAL_D  = 3'd4,
    FLT_MOD      = 3'd5
  } ptlb_fault_e;

  localparam int PG_LSB      = 11;
  localparam int SHIFT_BIG   = 12;
  localparam int SHIFT_SMALL = 10;
endpackage

// File: rtl/ptlb_slots.sv
module ptlb_slots #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int VPN_W   = 21,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 8,
  parameter int PFN_W   = 20,
  parameter int CA_W    = 3,
  parameter int SH_W    = 5,
  parameter int IDX_W   = 3,
  localparam int IW     = IDX_W + 1,
  localparam int RB_W   = PFN_W + CA_W + 3,
  localparam int PAD_W  = VA_W - VPN_W - ASID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              small_pg,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              wr_glob,
  input  logic [PFN_W-1:0]  wr_pfn_e,
  input  logic [CA_W-1:0]   wr_ca_e,
  input  logic              wr_dirty_e,
  input  logic              wr_valid_e,
  input  logic [PFN_W-1:0]  wr_pfn_o,
  input  logic [CA_W-1:0]   wr_ca_o,
  input  logic              wr_dirty_o,
  input  logic              wr_valid_o,
  input  logic [IW-1:0]     rd_idx,
  output logic [VA_W-1:0]   rd_tag,
  output logic [RB_W-1:0]   rd_even,
  output logic [RB_W-1:0]   rd_odd,
  output logic [MASK_W-1:0] rd_mask,
  output logic [VPN_W-1:0]  e_vpn   [ENTRIES],
  output logic [ASID_W-1:0] e_asid  [ENTRIES],
  output logic [MASK_W-1:0] e_mask  [ENTRIES],
  output logic              e_glob  [ENTRIES],
  output logic [SH_W-1:0]   e_shift [ENTRIES],
  output logic [PFN_W-1:0]  e_pfn_e [ENTRIES],
  output logic [PFN_W-1:0]  e_pfn_o [ENTRIES],
  output logic              e_d_e   [ENTRIES],
  output logic              e_d_o   [ENTRIES],
  output logic              e_v_e   [ENTRIES],
  output logic              e_v_o   [ENTRIES]
);
  import ptlb_pkg::*;

  logic [CA_W-1:0] e_ca_e [ENTRIES];
  logic [CA_W-1:0] e_ca_o [ENTRIES];

  function automatic logic [SH_W-1:0] page_shift(input logic [MASK_W-1:0] m,
                                                 input logic sm);
    logic [SH_W-1:0] s;
    s = sm ? SH_W'(SHIFT_SMALL) : SH_W'(SHIFT_BIG);
    for (int b = 0; b < MASK_W; b++) s = s + SH_W'(m[b]);
    return s;
  endfunction

  wire wr_ok = wr_en && (wr_idx < IW'(ENTRIES));
  wire [IDX_W-1:0] wr_sel = wr_idx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i]   <= '0;
        e_asid[i]  <= '0;
        e_mask[i]  <= '0;
        e_glob[i]  <= 1'b0;
        e_shift[i] <= '0;
        e_pfn_e[i] <= '0;
        e_pfn_o[i] <= '0;
        e_ca_e[i]  <= '0;
        e_ca_o[i]  <= '0;
        e_d_e[i]   <= 1'b0;
        e_d_o[i]   <= 1'b0;
        e_v_e[i]   <= 1'b0;
        e_v_o[i]   <= 1'b0;
      end
    end else if (wr_ok) begin
      e_vpn[wr_sel]   <= wr_vpn;
      e_asid[wr_sel]  <= wr_asid;
      e_mask[wr_sel]  <= wr_mask;
      e_glob[wr_sel]  <= wr_glob;
      e_shift[wr_sel] <= page_shift(wr_mask, small_pg);
      e_pfn_e[wr_sel] <= wr_pfn_e;
      e_pfn_o[wr_sel] <= wr_pfn_o;
      e_ca_e[wr_sel]  <= wr_ca_e;
      e_ca_o[wr_sel]  <= wr_ca_o;
      e_d_e[wr_sel]   <= wr_dirty_e;
      e_d_o[wr_sel]   <= wr_dirty_o;
      e_v_e[wr_sel]   <= wr_valid_e;
      e_v_o[wr_sel]   <= wr_valid_o;
    end
  end

  wire             rd_ok  = rd_idx < IW'(ENTRIES);
  wire [IDX_W-1:0] rd_sel = rd_idx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || !rd_ok) begin
      rd_tag  <= '0;
      rd_even <= '0;
      rd_odd  <= '0;
      rd_mask <= '0;
    end else begin
      rd_tag  <= {e_vpn[rd_sel], {PAD_W{1'b0}}, e_asid[rd_sel]};
      rd_even <= {e_pfn_e[rd_sel], e_ca_e[rd_sel], e_d_e[rd_sel],
                  e_v_e[rd_sel], e_glob[rd_sel]};
      rd_odd  <= {e_pfn_o[rd_sel], e_ca_o[rd_sel], e_d_o[rd_sel],
                  e_v_o[rd_sel], e_glob[rd_sel]};
      rd_mask <= e_mask[rd_sel];
    end
  end

  logic [ENTRIES-1:0] live;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_live
    assign live[g] = e_v_e[g] | e_v_o[g];
  end

  // R9
  oob_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ok && !flush) |=> (live == $past(live)));
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (live == '0));
endmodule

// File: rtl/ptlb_match.sv
module ptlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 21,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              small_pg,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [VPN_W-1:0]  e_vpn  [ENTRIES],
  input  logic [ASID_W-1:0] e_asid [ENTRIES],
  input  logic [MASK_W-1:0] e_mask [ENTRIES],
  input  logic              e_glob [ENTRIES],
  input  logic              e_v_e  [ENTRIES],
  input  logic              e_v_o  [ENTRIES],
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [ENTRIES-1:0] hv;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] ign;
    always_comb begin
      ign = '0;
      if (small_pg) begin
        ign[MASK_W-1:0] = e_mask[g];
      end else begin
        ign[MASK_W+1:2] = e_mask[g];
        ign[1:0]        = 2'b11;
      end
    end
    assign hv[g] = (e_v_e[g] | e_v_o[g]) &&
                   (e_glob[g] || (q_asid == e_asid[g])) &&
                   (((q_vpn ^ e_vpn[g]) & ~ign) == '0);
  end

  always_comb begin
    hit = |hv;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hv[i]) idx = IDX_W'(i);
  end

  // R11
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hv[idx] && ((hv & ((ENTRIES'(1) << idx) - ENTRIES'(1))) == '0)));
endmodule

// File: rtl/ptlb_xlate.sv
module ptlb_xlate #(
  parameter int VA_W  = 32,
  parameter int PFN_W = 20,
  parameter int SH_W  = 5,
  localparam int PA_W = PFN_W + 12
) (
  input  logic              hit,
  input  logic [VA_W-1:0]   va,
  input  logic              ifetch,
  input  logic              write,
  input  logic [SH_W-1:0]   shift,
  input  logic [PFN_W-1:0]  pfn_e,
  input  logic [PFN_W-1:0]  pfn_o,
  input  logic              d_e,
  input  logic              d_o,
  input  logic              v_e,
  input  logic              v_o,
  output ptlb_pkg::ptlb_fault_e fault,
  output logic [PA_W-1:0]   pa
);
  import ptlb_pkg::*;

  logic            odd;
  logic [PA_W-1:0] om, base;

  always_comb begin
    odd  = va[shift];
    om   = (PA_W'(1) << shift) - PA_W'(1);
    base = {(odd ? pfn_o : pfn_e), 12'h000};
    pa   = '0;
    if (!hit)
      fault = ifetch ? FLT_REFILL_I : FLT_REFILL_D;
    else if (!(odd ? v_o : v_e))
      fault = ifetch ? FLT_INVAL_I : FLT_INVAL_D;
    else if (!ifetch && write && !(odd ? d_o : d_e))
      fault = FLT_MOD;
    else begin
      fault = FLT_NONE;
      pa    = (base & ~om) | (PA_W'(va) & om);
    end
  end
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 8,
  parameter int PFN_W   = 20,
  parameter int CA_W    = 3,
  localparam int VPN_W  = VA_W - ptlb_pkg::PG_LSB,
  localparam int PA_W   = PFN_W + 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int IW     = IDX_W + 1,
  localparam int SH_W   = $clog2(VA_W),
  localparam int RB_W   = PFN_W + CA_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              small_pg,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_ifetch,
  input  logic              lk_write,
  output logic              lk_vld,
  output logic [2:0]        lk_fault,
  output logic [PA_W-1:0]   lk_pa,
  output logic [VA_W-1:0]   lk_badva,
  output logic [ASID_W-1:0] lk_f_asid,
  output logic [VPN_W-3:0]  lk_vpn2,
  output logic [1:0]        lk_vpn2x,
  output logic [VPN_W-3:0]  lk_ctx_vpn2,
  input  logic              pr_req,
  input  logic [VA_W-1:0]   pr_va,
  input  logic [ASID_W-1:0] pr_asid,
  output logic              pr_vld,
  output logic              pr_found,
  output logic [IDX_W-1:0]  pr_idx,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              wr_glob,
  input  logic [PFN_W-1:0]  wr_pfn_e,
  input  logic [CA_W-1:0]   wr_ca_e,
  input  logic              wr_dirty_e,
  input  logic              wr_valid_e,
  input  logic [PFN_W-1:0]  wr_pfn_o,
  input  logic [CA_W-1:0]   wr_ca_o,
  input  logic              wr_dirty_o,
  input  logic              wr_valid_o,
  input  logic              flush,
  input  logic [IW-1:0]     rd_idx,
  output logic [VA_W-1:0]   rd_tag,
  output logic [RB_W-1:0]   rd_even,
  output logic [RB_W-1:0]   rd_odd,
  output logic [MASK_W-1:0] rd_mask
);
  import ptlb_pkg::*;

  logic [VPN_W-1:0]  e_vpn   [ENTRIES];
  logic [ASID_W-1:0] e_asid  [ENTRIES];
  logic [MASK_W-1:0] e_mask  [ENTRIES];
  logic              e_glob  [ENTRIES];
  logic [SH_W-1:0]   e_shift [ENTRIES];
  logic [PFN_W-1:0]  e_pfn_e [ENTRIES];
  logic [PFN_W-1:0]  e_pfn_o [ENTRIES];
  logic              e_d_e   [ENTRIES];
  logic              e_d_o   [ENTRIES];
  logic              e_v_e   [ENTRIES];
  logic              e_v_o   [ENTRIES];

  ptlb_slots #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .VPN_W(VPN_W), .ASID_W(ASID_W),
    .MASK_W(MASK_W), .PFN_W(PFN_W), .CA_W(CA_W), .SH_W(SH_W), .IDX_W(IDX_W)
  ) u_slots (
    .clk(clk), .rst(rst), .flush(flush), .small_pg(small_pg),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_mask(wr_mask), .wr_glob(wr_glob),
    .wr_pfn_e(wr_pfn_e), .wr_ca_e(wr_ca_e), .wr_dirty_e(wr_dirty_e),
    .wr_valid_e(wr_valid_e), .wr_pfn_o(wr_pfn_o), .wr_ca_o(wr_ca_o),
    .wr_dirty_o(wr_dirty_o), .wr_valid_o(wr_valid_o),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_even(rd_even), .rd_odd(rd_odd),
    .rd_mask(rd_mask),
    .e_vpn(e_vpn), .e_asid(e_asid), .e_mask(e_mask), .e_glob(e_glob),
    .e_shift(e_shift), .e_pfn_e(e_pfn_e), .e_pfn_o(e_pfn_o),
    .e_d_e(e_d_e), .e_d_o(e_d_o), .e_v_e(e_v_e), .e_v_o(e_v_o)
  );

  // page number from bit 11; low pair cleared outside small-page mode
  function automatic logic [VPN_W-1:0] page_num(input logic [VA_W-1:0] a,
                                               input logic sm);
    logic [VPN_W-1:0] v;
    v = a[VA_W-1:PG_LSB];
    if (!sm) v[1:0] = 2'b00;
    return v;
  endfunction

  logic [VPN_W-1:0] lk_vpn, pr_vpn;
  assign lk_vpn = page_num(lk_va, small_pg);
  assign pr_vpn = page_num(pr_va, small_pg);

  logic             lk_hit, pr_hit;
  logic [IDX_W-1:0] lk_idx, pr_sel;

  ptlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .MASK_W(MASK_W),
    .IDX_W(IDX_W)
  ) u_lk_match (
    .clk(clk), .rst(rst), .small_pg(small_pg), .q_vpn(lk_vpn),
    .q_asid(lk_asid), .e_vpn(e_vpn), .e_asid(e_asid), .e_mask(e_mask),
    .e_glob(e_glob), .e_v_e(e_v_e), .e_v_o(e_v_o),
    .hit(lk_hit), .idx(lk_idx)
  );

  ptlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .MASK_W(MASK_W),
    .IDX_W(IDX_W)
  ) u_pr_match (
    .clk(clk), .rst(rst), .small_pg(small_pg), .q_vpn(pr_vpn),
    .q_asid(pr_asid), .e_vpn(e_vpn), .e_asid(e_asid), .e_mask(e_mask),
    .e_glob(e_glob), .e_v_e(e_v_e), .e_v_o(e_v_o),
    .hit(pr_hit), .idx(pr_sel)
  );

  ptlb_fault_e     x_fault;
  logic [PA_W-1:0] x_pa;

  ptlb_xlate #(.VA_W(VA_W), .PFN_W(PFN_W), .SH_W(SH_W)) u_xlate (
    .hit(lk_hit), .va(lk_va), .ifetch(lk_ifetch), .write(lk_write),
    .shift(e_shift[lk_idx]), .pfn_e(e_pfn_e[lk_idx]),
    .pfn_o(e_pfn_o[lk_idx]), .d_e(e_d_e[lk_idx]), .d_o(e_d_o[lk_idx]),
    .v_e(e_v_e[lk_idx]), .v_o(e_v_o[lk_idx]),
    .fault(x_fault), .pa(x_pa)
  );

  wire x_flt = (x_fault != FLT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_vld      <= 1'b0;
      lk_fault    <= '0;
      lk_pa       <= '0;
      lk_badva    <= '0;
      lk_f_asid   <= '0;
      lk_vpn2     <= '0;
      lk_vpn2x    <= '0;
      lk_ctx_vpn2 <= '0;
      pr_vld      <= 1'b0;
      pr_found    <= 1'b0;
      pr_idx      <= '0;
    end else begin
      lk_vld <= lk_req;
      if (lk_req) begin
        lk_fault    <= x_fault;
        lk_pa       <= x_pa;
        lk_badva    <= x_flt ? lk_va : '0;
        lk_f_asid   <= x_flt ? lk_asid : '0;
        lk_vpn2     <= x_flt ? lk_vpn[VPN_W-1:2] : '0;
        lk_vpn2x    <= x_flt ? lk_vpn[1:0] : '0;
        lk_ctx_vpn2 <= x_flt ? lk_vpn[VPN_W-1:2] : '0;
      end
      pr_vld <= pr_req;
      if (pr_req) begin
        pr_found <= pr_hit;
        pr_idx   <= pr_hit ? pr_sel : '0;
      end
    end
  end

  // R12
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    lk_vld |-> $past(lk_req));
  // R4
  refill_side_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_vld && lk_fault == 3'd1) |-> $past(lk_ifetch));
  // R6
  mod_write_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_vld && lk_fault == 3'd5) |-> $past(lk_write && !lk_ifetch));
  // R8
  pa_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_vld && lk_fault != 3'd0) |-> (lk_pa == '0));
endmodule

// File: tb/tb_ptlb_top.sv
`timescale 1ns/1ps
module tb_ptlb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic small_pg = 0, lk_req = 0, lk_ifetch = 0, lk_write = 0;
  logic [31:0] lk_va = 0;
  logic [7:0]  lk_asid = 0;
  logic lk_vld;
  logic [2:0] lk_fault;
  logic [31:0] lk_pa, lk_badva;
  logic [7:0] lk_f_asid;
  logic [18:0] lk_vpn2, lk_ctx_vpn2;
  logic [1:0] lk_vpn2x;
  logic pr_req = 0;
  logic [31:0] pr_va = 0;
  logic [7:0] pr_asid = 0;
  logic pr_vld, pr_found;
  logic [2:0] pr_idx;
  logic wr_en = 0, wr_glob = 0, wr_dirty_e = 0, wr_valid_e = 0;
  logic wr_dirty_o = 0, wr_valid_o = 0, flush = 0;
  logic [3:0] wr_idx = 0, rd_idx = 0;
  logic [20:0] wr_vpn = 0;
  logic [7:0] wr_asid = 0, wr_mask = 0;
  logic [19:0] wr_pfn_e = 0, wr_pfn_o = 0;
  logic [2:0] wr_ca_e = 0, wr_ca_o = 0;
  logic [31:0] rd_tag;
  logic [25:0] rd_even, rd_odd;
  logic [7:0] rd_mask;

  ptlb_top dut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic check(input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wslot(input logic [3:0] idx, input logic [20:0] vpn,
                       input logic [7:0] asid, input logic [7:0] msk,
                       input logic g, input logic [19:0] pe,
                       input logic [2:0] ce, input logic de, input logic ve,
                       input logic [19:0] po, input logic [2:0] co,
                       input logic do_, input logic vo);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_mask = msk;
    wr_glob = g; wr_pfn_e = pe; wr_ca_e = ce; wr_dirty_e = de;
    wr_valid_e = ve; wr_pfn_o = po; wr_ca_o = co; wr_dirty_o = do_;
    wr_valid_o = vo;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid,
                      input logic ifc, input logic wr, input logic sm);
    @(negedge clk);
    lk_req = 1; lk_va = va; lk_asid = asid; lk_ifetch = ifc;
    lk_write = wr; small_pg = sm;
    @(negedge clk);
    lk_req = 0; small_pg = 0;
  endtask

  task automatic probe(input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    pr_req = 1; pr_va = va; pr_asid = asid;
    @(negedge clk);
    pr_req = 0;
  endtask

  task automatic rback(input logic [3:0] idx);
    @(negedge clk);
    rd_idx = idx;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        ifc;
    logic        wr;
    logic        sm;
    logic [2:0]  flt;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_0123, 8'd5, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0011_1123},
    '{32'h0040_1456, 8'd5, 1'b0, 1'b1, 1'b0, 3'd5, 32'h0},
    '{32'h0040_1456, 8'd5, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0022_2456},
    '{32'h0040_1456, 8'd5, 1'b1, 1'b1, 1'b0, 3'd0, 32'h0022_2456},
    '{32'h0040_0123, 8'd6, 1'b0, 1'b0, 1'b0, 3'd2, 32'h0},
    '{32'h0040_0123, 8'd6, 1'b1, 1'b0, 1'b0, 3'd1, 32'h0},
    '{32'h1000_2ABC, 8'd3, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0030_2ABC},
    '{32'h1000_4010, 8'd3, 1'b1, 1'b0, 1'b0, 3'd3, 32'h0},
    '{32'h1000_4010, 8'd3, 1'b0, 1'b1, 1'b0, 3'd4, 32'h0},
    '{32'h1000_8000, 8'd3, 1'b0, 1'b0, 1'b0, 3'd2, 32'h0},
    '{32'h0040_0923, 8'd5, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0011_1923},
    '{32'h0040_0923, 8'd5, 1'b0, 1'b0, 1'b1, 3'd2, 32'h0},
    '{32'h2000_0010, 8'd1, 1'b0, 1'b0, 1'b0, 3'd0, 32'h000B_B010},
    '{32'h0040_0123, 8'd5, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0011_1123}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R12: reset state
    check("R12 reset lk_vld", lk_vld, 0);
    check("R12 reset lk_pa", lk_pa, 0);
    check("R12 reset pr_vld", pr_vld, 0);
    check("R12 reset rd_tag", rd_tag, 0);

    wslot(4'd0, 21'h800, 8'd5, 8'h00, 0, 20'h111, 3'd3, 1, 1,
          20'h222, 3'd2, 0, 1);
    wslot(4'd1, 21'h20000, 8'd9, 8'h03, 1, 20'h301, 3'd0, 1, 1,
          20'h3A5, 3'd0, 0, 0);
    wslot(4'd2, 21'h40000, 8'd0, 8'h00, 1, 20'h0BB, 3'd0, 1, 1,
          20'h0, 3'd0, 0, 0);
    wslot(4'd3, 21'h40000, 8'd1, 8'h00, 0, 20'h0AA, 3'd0, 1, 1,
          20'h0, 3'd0, 0, 0);

    // vector walk: R1 R2 R3 R4 R5 R6 R8 R11
    for (int i = 0; i < NV; i++) begin
      look(VECS[i].va, VECS[i].asid, VECS[i].ifc, VECS[i].wr, VECS[i].sm);
      check($sformatf("R1 R3 R4 R5 R6 vec %0d fault", i), lk_fault,
            VECS[i].flt);
      check($sformatf("R8 vec %0d pa", i), lk_pa, VECS[i].pa);
      check($sformatf("R12 vec %0d strobe", i), lk_vld, 1);
    end
    @(negedge clk);
    check("R12 strobe one cycle", lk_vld, 0);

    // R7: fault fields, big pages
    look(32'h1000_8000, 8'd3, 0, 0, 0);
    check("R7 badva", lk_badva, 32'h1000_8000);
    check("R7 asid", lk_f_asid, 8'd3);
    check("R7 vpn2", lk_vpn2, 19'h8004);
    check("R7 vpn2x", lk_vpn2x, 2'd0);
    check("R7 ctx", lk_ctx_vpn2, 19'h8004);
    // R2 R7: small pages keep low page bits
    look(32'h0040_0923, 8'd6, 0, 0, 1);
    check("R2 small vpn2x", lk_vpn2x, 2'd1);
    check("R7 small vpn2", lk_vpn2, 19'h200);
    // R7: no fault clears fields
    look(32'h0040_0123, 8'd5, 0, 0, 0);
    check("R7 clean badva", lk_badva, 0);

    // R11 probe
    probe(32'h2000_0010, 8'd1);
    check("R11 probe found", pr_found, 1);
    check("R11 probe idx", pr_idx, 3'd2);
    check("R12 probe strobe", pr_vld, 1);
    probe(32'h0040_0000, 8'd7);
    check("R11 probe miss", pr_found, 0);
    check("R11 probe miss idx", pr_idx, 3'd0);

    // R10 readback
    rback(4'd0);
    check("R10 tag", rd_tag, 32'h0040_0005);
    check("R10 even", rd_even, 26'h445E);
    check("R10 odd", rd_odd, 26'h8892);
    rback(4'd1);
    check("R10 global even", rd_even, 26'hC047);
    check("R10 mask", rd_mask, 8'h03);

    // R9 out-of-range write ignored
    wslot(4'd8, 21'h800, 8'd5, 8'h00, 0, 20'h777, 3'd1, 1, 1,
          20'h777, 3'd1, 1, 1);
    rback(4'd0);
    check("R9 oob even unchanged", rd_even, 26'h445E);
    look(32'h0040_1456, 8'd5, 0, 1, 0);
    check("R9 oob lookup unchanged", lk_fault, 3'd5);

    // R9 flush
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    rback(4'd0);
    check("R9 flush tag", rd_tag, 0);
    check("R9 flush even", rd_even, 0);
    look(32'h0040_0123, 8'd5, 0, 0, 0);
    check("R9 flush refill", lk_fault, 3'd2);
    look(32'h0000_0000, 8'd0, 1, 0, 0);
    check("R1 empty slot no match", lk_fault, 3'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule